// File: doc/BRIEF.md
# Two-Word Packet Serial Receiver

This block collects 32-bit packets from a single serial data line and queues them for a host that reads 16 bits at a time over a small port bus. Each bit is qualified by an external sample strobe, so clock recovery is outside the block. A packet begins when a start input is seen while the receiver is enabled. Exactly 32 qualified bits make a packet, assembled least significant bit first. The packet is then written into a four-entry queue.

The host controls the receiver through five addresses above a base address. A write to the control address turns reception on or off. A read of the fetch address moves the oldest queued packet into a 32-bit holding register. Reads of the low and high addresses return the two halves of that register, and a read of the status address returns the flags.

The receive controller is a four-state machine:
- IDLE: reception is off. It leaves for ARMED once enabled.
- ARMED: it waits for the start input. The start input takes it to SHIFT.
- SHIFT: it samples bits. The 32nd bit takes it to STORE.
- STORE: it writes the packet and returns to ARMED as soon as the queue has room. A bit strobe that arrives while the queue is still full discards the packet, raises overrun and also returns to ARMED.

Clearing the enable sends any state back to IDLE one cycle later.

Top module: `pkt_rx_top`

## Requirements
- R1: After reset, tx_rx_o, fifo_full_o, fifo_wr_o, overrun_o and underflow_o are 0, fifo_empty_o is 1, the holding register is zero and port_dout_o is zero.
- R2: A write to BASE+0 loads port_din_i bit 0 into tx_rx_o in the next cycle. While tx_rx_o is 0, the start, strobe and data inputs store nothing.
- R3: A cycle with rx_start_i high in ARMED starts a packet. Each later cycle with rx_bit_vld_i high samples rxd_i, least significant bit first. After exactly 32 samples, the next cycle with queue room pulses fifo_wr_o and queues the word.
- R4: The queue holds four packets and returns them oldest first. fifo_full_o is 1 with four entries and fifo_empty_o is 1 with none.
- R5: A packet completed while the queue is full is held in STORE. It is written, with fifo_wr_o high, in the same cycle that a fetch frees an entry.
- R6: A bit strobe while a completed packet waits in STORE with a full queue discards that packet and sets overrun_o, which stays set until reset.
- R7: A read of BASE+1 with a non-empty queue moves the oldest packet into the holding register and removes it from the queue.
- R8: A read of BASE+1 with an empty queue leaves the holding register unchanged and sets underflow_o, which stays set until reset.
- R9: During a read, port_dout_o shows holding register bits 15:0 at BASE+2 and bits 31:16 at BASE+3. It shows zero when no read of BASE+2, BASE+3 or BASE+4 is in progress.
- R10: A read of BASE+4 returns status. Bit 0 is tx_rx, bit 1 empty, bit 2 full, bit 3 overrun, bit 4 underflow, bits 7:5 hold the entry count, and the other bits are zero.
- R11: Clearing the enable discards a packet in progress. After re-enabling, the next packet is received whole and correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_addr_i | input | ADDR_W | Port bus address |
| port_wr_i | input | 1 | Port write strobe |
| port_rd_i | input | 1 | Port read strobe |
| port_din_i | input | HALF_W | Port write data |
| port_dout_o | output | HALF_W | Port read data |
| rxd_i | input | 1 | Serial data line |
| rx_start_i | input | 1 | Packet start enable |
| rx_bit_vld_i | input | 1 | Bit sample strobe |
| tx_rx_o | output | 1 | Receiver enabled |
| fifo_wr_o | output | 1 | Queue write pulse |
| fifo_full_o | output | 1 | Queue full |
| fifo_empty_o | output | 1 | Queue empty |
| overrun_o | output | 1 | Sticky dropped-packet flag |
| underflow_o | output | 1 | Sticky empty-fetch flag |

## Verification
A wrong bit count or shift direction appears at the low and high read data one fetch after the packet was queued. A queue pointer or count error appears at the full and empty flags on the next cycle. It also appears as misordered packets at the first fetch. A controller stuck in STORE, or one that leaves it wrongly, shows within one cycle as a missing or extra fifo_wr_o pulse. A reference model is compared with these outputs on every clock, so each such fault is reported in the cycle it first becomes visible.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_ARMED = 2'd1,
        RX_SHIFT = 2'd2,
        RX_STORE = 2'd3
    } rx_state_e;

    // port offsets above the base address
    localparam int OFS_CTRL = 0;
    localparam int OFS_POP  = 1;
    localparam int OFS_LO   = 2;
    localparam int OFS_HI   = 3;
    localparam int OFS_STAT = 4;

    // status bit positions
    localparam int ST_EN    = 0;
    localparam int ST_EMPTY = 1;
    localparam int ST_FULL  = 2;
    localparam int ST_OVR   = 3;
    localparam int ST_UDF   = 4;
    localparam int ST_CNT   = 5;

endpackage

// File: rtl/pkt_rx_dec.sv
module pkt_rx_dec #(
    parameter int          ADDR_W    = 8,
    parameter logic [7:0]  BASE_ADDR = 8'h40
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output logic              ctrl_wr,
    output logic              pop_rd,
    output logic              lo_rd,
    output logic              hi_rd,
    output logic              stat_rd
);
    import pkt_rx_pkg::*;

    localparam logic [ADDR_W-1:0] A_BASE = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] A_CTRL = A_BASE + ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_POP  = A_BASE + ADDR_W'(OFS_POP);
    localparam logic [ADDR_W-1:0] A_LO   = A_BASE + ADDR_W'(OFS_LO);
    localparam logic [ADDR_W-1:0] A_HI   = A_BASE + ADDR_W'(OFS_HI);
    localparam logic [ADDR_W-1:0] A_STAT = A_BASE + ADDR_W'(OFS_STAT);

    always_comb begin
        ctrl_wr = wr && (addr == A_CTRL);
        pop_rd  = rd && (addr == A_POP);
        lo_rd   = rd && (addr == A_LO);
        hi_rd   = rd && (addr == A_HI);
        stat_rd = rd && (addr == A_STAT);
    end

endmodule

// File: rtl/pkt_rx_fifo.sv
module pkt_rx_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt_q;

    function automatic logic [PTR_W-1:0] inc_ptr(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) wr_ptr <= inc_ptr(wr_ptr);
            if (pop)  rd_ptr <= inc_ptr(rd_ptr);
            unique case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_comb begin
        head  = mem[rd_ptr];
        count = cnt_q;
        full  = (cnt_q == CNT_W'(DEPTH));
        empty = (cnt_q == '0);
    end

    // R4: the queue is never popped while empty
    assert_no_pop_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

    // R5: a push into a full queue only happens alongside a pop
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |-> pop);

    // R4: the count stays within the depth
    assert_count_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));

endmodule

// File: rtl/pkt_rx_deser.sv
module pkt_rx_deser #(
    parameter int W = 32,
    localparam int BCNT_W = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         start,
    input  logic         bit_vld,
    input  logic         rxd,
    input  logic         space,
    output logic         push,
    output logic         drop,
    output logic [W-1:0] word
);
    import pkt_rx_pkg::*;

    localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(W - 1);

    rx_state_e         state_q, state_d;
    logic [W-1:0]      shreg_q;
    logic [BCNT_W-1:0] bitcnt_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        push    = 1'b0;
        drop    = 1'b0;
        if (!en) begin
            state_d = RX_IDLE;
        end else begin
            unique case (state_q)
                RX_IDLE:  state_d = RX_ARMED;
                RX_ARMED: if (start) state_d = RX_SHIFT;
                RX_SHIFT: if (bit_vld && bitcnt_q == LAST_BIT) state_d = RX_STORE;
                RX_STORE: begin
                    if (space) begin
                        push    = 1'b1;
                        state_d = RX_ARMED;
                    end else if (bit_vld) begin
                        drop    = 1'b1;
                        state_d = RX_ARMED;
                    end
                end
            endcase
        end
    end

    // bit assembly, least significant bit first
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q  <= '0;
            bitcnt_q <= '0;
        end else if (en) begin
            if (state_q == RX_ARMED && start) begin
                bitcnt_q <= '0;
            end else if (state_q == RX_SHIFT && bit_vld) begin
                shreg_q  <= {rxd, shreg_q[W-1:1]};
                bitcnt_q <= bitcnt_q + 1'b1;
            end
        end
    end

    assign word = shreg_q;

    // R11: clearing the enable always returns the controller to IDLE
    assert_idle_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state_q == RX_IDLE));

    // R3: a start seen while armed opens a packet with a cleared bit count
    assert_start_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state_q == RX_ARMED && start) |=> (state_q == RX_SHIFT && bitcnt_q == '0));

    // R6: a discard never coincides with a write
    assert_drop_xor_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && drop));

endmodule

// File: rtl/pkt_rx_top.sv
module pkt_rx_top #(
    parameter int         ADDR_W    = 8,
    parameter logic [7:0] BASE_ADDR = 8'h40,
    parameter int         HALF_W    = 16,
    parameter int         DEPTH     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] port_addr_i,
    input  logic              port_wr_i,
    input  logic              port_rd_i,
    input  logic [HALF_W-1:0] port_din_i,
    output logic [HALF_W-1:0] port_dout_o,
    input  logic              rxd_i,
    input  logic              rx_start_i,
    input  logic              rx_bit_vld_i,
    output logic              tx_rx_o,
    output logic              fifo_wr_o,
    output logic              fifo_full_o,
    output logic              fifo_empty_o,
    output logic              overrun_o,
    output logic              underflow_o
);
    import pkt_rx_pkg::*;

    localparam int WORD_W = 2 * HALF_W;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic              ctrl_wr, pop_rd, lo_rd, hi_rd, stat_rd;
    logic              en_q, ovr_q, udf_q;
    logic              push, drop, pop, space;
    logic              full, empty;
    logic [CNT_W-1:0]  count;
    logic [WORD_W-1:0] word, head, hold_q;
    logic [HALF_W-1:0] status;

    pkt_rx_dec #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
        .addr    (port_addr_i),
        .wr      (port_wr_i),
        .rd      (port_rd_i),
        .ctrl_wr (ctrl_wr),
        .pop_rd  (pop_rd),
        .lo_rd   (lo_rd),
        .hi_rd   (hi_rd),
        .stat_rd (stat_rd)
    );

    assign pop   = pop_rd && !empty;
    assign space = !full || pop;

    pkt_rx_deser #(.W(WORD_W)) u_deser (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en_q),
        .start   (rx_start_i),
        .bit_vld (rx_bit_vld_i),
        .rxd     (rxd_i),
        .space   (space),
        .push    (push),
        .drop    (drop),
        .word    (word)
    );

    pkt_rx_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   (word),
        .pop   (pop),
        .head  (head),
        .count (count),
        .full  (full),
        .empty (empty)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            ovr_q  <= 1'b0;
            udf_q  <= 1'b0;
            hold_q <= '0;
        end else begin
            if (ctrl_wr)          en_q   <= port_din_i[0];
            if (drop)             ovr_q  <= 1'b1;
            if (pop_rd && empty)  udf_q  <= 1'b1;
            if (pop)              hold_q <= head;
        end
    end

    always_comb begin
        status           = '0;
        status[ST_EN]    = en_q;
        status[ST_EMPTY] = empty;
        status[ST_FULL]  = full;
        status[ST_OVR]   = ovr_q;
        status[ST_UDF]   = udf_q;
        status[ST_CNT +: CNT_W] = count;
    end

    always_comb begin
        port_dout_o = '0;
        if (lo_rd)        port_dout_o = hold_q[HALF_W-1:0];
        else if (hi_rd)   port_dout_o = hold_q[WORD_W-1:HALF_W];
        else if (stat_rd) port_dout_o = status;
    end

    assign tx_rx_o      = en_q;
    assign fifo_wr_o    = push;
    assign fifo_full_o  = full;
    assign fifo_empty_o = empty;
    assign overrun_o    = ovr_q;
    assign underflow_o  = udf_q;

    // R7: the holding register changes only after a successful fetch
    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pop) |-> $stable(hold_q));

    // R8: underflow is sticky
    assert_underflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(udf_q) |-> udf_q);

    // R6: overrun is sticky
    assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ovr_q) |-> ovr_q);

    // R2: nothing is queued while reception is off
    assert_no_write_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !fifo_wr_o);

endmodule

// File: tb/sim_pkt_rx_top.sv
`timescale 1ns/1ps
module sim_pkt_rx_top;

    localparam logic [7:0] BASE = 8'h40;
    localparam logic [7:0] A_CTRL = BASE + 8'd0;
    localparam logic [7:0] A_POP  = BASE + 8'd1;
    localparam logic [7:0] A_LO   = BASE + 8'd2;
    localparam logic [7:0] A_HI   = BASE + 8'd3;
    localparam logic [7:0] A_STAT = BASE + 8'd4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [15:0] din = '0;
    logic [15:0] dout;
    logic        rxd = 1'b0, st = 1'b0, bv = 1'b0;
    logic        tx_rx, fwr, ffull, fempty, ovr, udf;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pkt_rx_top u0 (
        .clk(clk), .rst_n(rst_n),
        .port_addr_i(addr), .port_wr_i(wr), .port_rd_i(rd),
        .port_din_i(din), .port_dout_o(dout),
        .rxd_i(rxd), .rx_start_i(st), .rx_bit_vld_i(bv),
        .tx_rx_o(tx_rx), .fifo_wr_o(fwr), .fifo_full_o(ffull),
        .fifo_empty_o(fempty), .overrun_o(ovr), .underflow_o(udf)
    );

    // behavioural reference model
    logic [31:0] q [$];
    logic [31:0] m_sh = '0, m_buf = '0;
    bit  m_en = 0, m_ovr = 0, m_udf = 0;
    int  m_phase = 0;   // 0 off, 1 waiting start, 2 collecting, 3 holding
    int  m_cnt = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] m_status();
        logic [15:0] s = '0;
        s[0] = m_en;
        s[1] = (q.size() == 0);
        s[2] = (q.size() == 4);
        s[3] = m_ovr;
        s[4] = m_udf;
        s[7:5] = 3'(q.size());
        return s;
    endfunction

    // one clock: drive at negedge, check combinational outputs, update model, check registered outputs
    task automatic step(input logic i_wr, input logic i_rd, input logic [7:0] i_addr,
                        input logic [15:0] i_din, input logic i_st, input logic i_bv,
                        input logic i_rxd);
        bit pop_ok, space, exp_wr, n_en;
        int n_phase;
        logic [15:0] exp_dout;
        wr = i_wr; rd = i_rd; addr = i_addr; din = i_din;
        st = i_st; bv = i_bv; rxd = i_rxd;
        #1;
        pop_ok = i_rd && (i_addr == A_POP) && (q.size() > 0);
        space  = (q.size() < 4) || pop_ok;
        exp_wr = m_en && (m_phase == 3) && space;
        exp_dout = '0;
        if (i_rd && i_addr == A_LO)   exp_dout = m_buf[15:0];
        if (i_rd && i_addr == A_HI)   exp_dout = m_buf[31:16];
        if (i_rd && i_addr == A_STAT) exp_dout = m_status();
        check("R3 fifo_wr", 32'(fwr), 32'(exp_wr));
        if (i_rd && i_addr == A_STAT) check("R10 status", 32'(dout), 32'(exp_dout));
        else                          check("R9 dout", 32'(dout), 32'(exp_dout));
        // model update
        if (i_rd && i_addr == A_POP) begin
            if (q.size() > 0) m_buf = q.pop_front();
            else              m_udf = 1;
        end
        n_phase = m_phase;
        if (!m_en) n_phase = 0;
        else case (m_phase)
            0: n_phase = 1;
            1: if (i_st) begin n_phase = 2; m_cnt = 0; end
            2: if (i_bv) begin
                   m_sh = {i_rxd, m_sh[31:1]};
                   m_cnt++;
                   if (m_cnt == 32) n_phase = 3;
               end
            default: if (space) begin q.push_back(m_sh); n_phase = 1; end
                     else if (i_bv) begin m_ovr = 1; n_phase = 1; end
        endcase
        n_en = m_en;
        if (i_wr && i_addr == A_CTRL) n_en = i_din[0];
        m_phase = n_phase;
        m_en = n_en;
        @(posedge clk);
        @(negedge clk);
        check("R2 tx_rx", 32'(tx_rx), 32'(m_en));
        check("R4 empty", 32'(fempty), 32'(q.size() == 0));
        check("R4 full", 32'(ffull), 32'(q.size() == 4));
        check("R6 overrun", 32'(ovr), 32'(m_ovr));
        check("R8 underflow", 32'(udf), 32'(m_udf));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 8'h00, 16'h0, 0, 0, 0);
    endtask

    task automatic ctrl(input logic v);
        step(1, 0, A_CTRL, {15'h0, v}, 0, 0, 0);
    endtask

    task automatic pop();
        step(0, 1, A_POP, 16'h0, 0, 0, 0);
    endtask

    // start pulse, 32 bits with a gap after every fifth bit, then one quiet cycle
    task automatic send_word(input logic [31:0] w);
        step(0, 0, 8'h00, 16'h0, 1, 0, 0);
        for (int i = 0; i < 32; i++) begin
            step(0, 0, 8'h00, 16'h0, 0, 1, w[i]);
            if (i % 5 == 4) idle(1);
        end
        idle(1);
    endtask

    task automatic read_word(output logic [31:0] w);
        rd = 1; addr = A_LO; #1; w[15:0] = dout;
        step(0, 1, A_LO, 16'h0, 0, 0, 0);
        rd = 1; addr = A_HI; #1; w[31:16] = dout;
        step(0, 1, A_HI, 16'h0, 0, 0, 0);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] got;
        logic [31:0] w [1:8];
        w[1] = 32'h1234_5678; w[2] = 32'h8000_0001; w[3] = 32'hFFFF_0000;
        w[4] = 32'h0F0F_F0F0; w[5] = 32'hDEAD_BEEF; w[6] = 32'h5555_AAAA;
        w[7] = 32'hCAFE_F00D; w[8] = 32'h0BAD_C0DE;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 tx_rx", 32'(tx_rx), 0);
        check("R1 empty", 32'(fempty), 1);
        check("R1 full", 32'(ffull), 0);
        check("R1 overrun", 32'(ovr), 0);
        check("R1 underflow", 32'(udf), 0);
        check("R1 fifo_wr", 32'(fwr), 0);
        check("R1 dout", 32'(dout), 0);
        read_word(got);
        check("R1 holding register", got, 32'h0);

        // R2 disabled receiver ignores serial activity
        send_word(32'hFFFF_FFFF);
        idle(2);
        check("R2 nothing stored while off", 32'(fempty), 1);

        ctrl(1);
        idle(1);

        // R3 single packet, LSB first
        send_word(32'hA5C3_0F01);
        pop();
        read_word(got);
        check("R3 R7 packet fetched", got, 32'hA5C3_0F01);

        // R4 fill the queue
        for (int k = 1; k <= 4; k++) send_word(w[k]);
        check("R4 full after four", 32'(ffull), 1);
        // R5 fifth packet waits for room
        send_word(w[5]);
        idle(3);
        check("R5 held while full", 32'(ffull), 1);
        addr = A_POP; rd = 1; #1;
        check("R5 write in fetch cycle", 32'(fwr), 1);
        pop();
        check("R5 still full after swap", 32'(ffull), 1);
        read_word(got);
        check("R4 oldest first", got, w[1]);
        pop();
        read_word(got);
        check("R4 order second", got, w[2]);

        // R6 overrun: refill, then a strobe while held drops the packet
        send_word(w[6]);
        send_word(w[7]);
        step(0, 0, 8'h00, 16'h0, 0, 1, 1);
        check("R6 overrun set", 32'(ovr), 1);
        for (int k = 0; k < 4; k++) pop();
        read_word(got);
        check("R6 dropped packet absent", got, w[6]);

        // R8 fetch on empty
        pop();
        check("R8 underflow set", 32'(udf), 1);
        read_word(got);
        check("R8 holding unchanged", got, w[6]);

        // R10 status word
        rd = 1; addr = A_STAT; #1;
        check("R10 status value", 32'(dout), 32'h0000_001B);
        step(0, 1, A_STAT, 16'h0, 0, 0, 0);

        // R11 abandon a partial packet
        step(0, 0, 8'h00, 16'h0, 1, 0, 0);
        for (int i = 0; i < 10; i++) step(0, 0, 8'h00, 16'h0, 0, 1, 1);
        ctrl(0);
        idle(2);
        check("R11 disabled", 32'(tx_rx), 0);
        ctrl(1);
        idle(1);
        send_word(w[8]);
        pop();
        read_word(got);
        check("R11 clean packet after restart", got, w[8]);
        idle(2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule